// File: doc/BRIEF.md
# Banked I2C Byte Memory Slave

This block is an I2C target that sits in front of a 256-byte on-chip memory. The bus lines reach it as sampled open-drain inputs. Its only bus output is a pull-low enable for the data line, and the board pull-up supplies every high level. A controller opens each transaction with a START condition. It then sends a device byte that carries a fixed memory type code, a bank number and a direction bit. The block answers only when the bank number equals its 3-bit strap input, so eight of these memories can share one bus.

In a write, the byte after the device byte sets the internal word pointer. Each byte after that is stored at the pointer, and the pointer then advances. In a read, the block returns bytes from the pointer onward for as long as the controller acknowledges them. A repeated START keeps the pointer. A controller can therefore set the pointer in a write, issue a repeated START and read from any location.

Top module: `i2c_bank_mem_slave`

## Requirements
- R1: During and after reset, sda_oe is 0 and the slave waits for a START.
- R2: A device byte (MSB first) whose bits 7..4 are 1010, whose bits 3..1 equal bank_sel and whose bit 0 is the direction bit is acknowledged: sda_oe is 1 throughout the high phase of the ninth SCL pulse.
- R3: A device byte with a wrong type code or a wrong bank gets no acknowledge. SDA stays released for the rest of that transaction, and bytes sent in it do not change the memory.
- R4: In a write (bit 0 = 0), the first byte after the device byte is acknowledged and becomes the word pointer.
- R5: Each later write byte is acknowledged and stored at the pointer. The pointer then increases by one.
- R6: The pointer wraps from 255 to 0, in writes and in reads alike.
- R7: In a read (bit 0 = 1), the slave sends the byte at the pointer MSB first and advances the pointer. It sends the next byte each time the controller acknowledges.
- R8: After a controller NACK on a read byte, SDA stays released until the next START.
- R9: A repeated START keeps the word pointer, so a write of the pointer followed by a repeated START and a read returns that location.
- R10: A STOP returns the slave to idle. A START at any point, including mid-byte, restarts device-byte reception.
- R11: sda_oe changes only while SCL is low.
- R12: Bytes clocked without a preceding START (after reset or after a STOP) are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired value) |
| bank_sel | input | 3 | Strap selecting which bank number the slave answers to |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The checks assume that each SCL level lasts several system clocks. They also assume that the controller moves SDA only while SCL is low, except when it makes a START or a STOP. Under those conditions, a change of the pull-low enable always falls in an SCL low phase, and a START or STOP is seen without any clash with the slave's own drive. The bench controller holds every bus phase for eight clocks. It issues START and STOP only while the slave is releasing SDA, so the stimulus never leaves these assumptions.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RD_ACK,
        ST_SKIP
    } slv_state_e;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[0] <= RST_VAL;
                else        stg_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= RST_VAL;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2cm_edge.sv
module i2cm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s &  scl_p_q;
    assign start_det =  scl_s &  scl_p_q &  sda_p_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_p_q & ~sda_p_q &  sda_s;
endmodule

// File: rtl/i2cm_ram.sv
module i2cm_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/i2c_bank_mem_slave.sv
module i2c_bank_mem_slave
    import i2cm_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = 8,
    parameter int          BANK_W      = 3,
    parameter logic [3:0]  TYPE_CODE   = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [BANK_W-1:0] bank_sel,
    output logic              sda_oe
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        slv_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic [BYTE_W-1:0] sh;
        logic [ADDR_W-1:0] ptr;
        logic              rw;
        logic              oe;
        logic              mack;
    } slv_regs_t;

    slv_regs_t d, q;

    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_data;
    logic              dev_match;
    slv_state_e        st_q;
    logic [ADDR_W-1:0] ptr_q;

    i2cm_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   ({scl_s, sda_s})
    );

    i2cm_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cm_ram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .addr  (q.ptr),
        .wdata (q.sh),
        .rdata (rd_data)
    );

    assign dev_match = (q.sh[7:4] == TYPE_CODE) && (q.sh[BANK_W:1] == bank_sel);

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (stop_det) begin
            d.st   = ST_IDLE;
            d.oe   = 1'b0;
            d.cnt  = '0;
            d.done = 1'b0;
        end else if (start_det) begin
            d.st   = ST_DEV;
            d.oe   = 1'b0;
            d.cnt  = '0;
            d.done = 1'b0;
        end else begin
            case (q.st)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(BYTE_W-1)) d.done = 1'b1;
                    end else if (scl_fall && q.done) begin
                        d.done = 1'b0;
                        d.cnt  = '0;
                        if (q.st == ST_DEV) begin
                            if (dev_match) begin
                                d.st = ST_DEV_ACK;
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                            end else begin
                                d.st = ST_SKIP;
                            end
                        end else if (q.st == ST_WADR) begin
                            d.ptr = q.sh[ADDR_W-1:0];
                            d.st  = ST_WADR_ACK;
                            d.oe  = 1'b1;
                        end else begin
                            wr_en = 1'b1;
                            d.ptr = q.ptr + 1'b1;
                            d.st  = ST_WDAT_ACK;
                            d.oe  = 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (q.rw) begin
                            d.sh  = rd_data;
                            d.oe  = ~rd_data[BYTE_W-1];
                            d.cnt = '0;
                            d.st  = ST_RDAT;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_WADR;
                        end
                    end
                end
                ST_WADR_ACK, ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(BYTE_W-1)) d.done = 1'b1;
                    end else if (scl_fall) begin
                        if (q.done) begin
                            d.done = 1'b0;
                            d.cnt  = '0;
                            d.oe   = 1'b0;
                            d.ptr  = q.ptr + 1'b1;
                            d.st   = ST_RD_ACK;
                        end else begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.sh  = rd_data;
                            d.oe  = ~rd_data[BYTE_W-1];
                            d.cnt = '0;
                            d.st  = ST_RDAT;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, done: 1'b0, sh: '0, ptr: '0,
                   rw: 1'b0, oe: 1'b0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign st_q   = q.st;
    assign ptr_q  = q.ptr;
endmodule

module i2cm_chk
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_en,
    input slv_state_e        st,
    input logic [ADDR_W-1:0] ptr
);
    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s); // R11

    AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_SKIP) |-> !sda_oe); // R8

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !sda_oe)); // R10

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (st == ST_DEV)); // R10

    AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R6
endmodule

bind i2c_bank_mem_slave i2cm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_en     (wr_en),
    .st        (st_q),
    .ptr       (ptr_q)
);

// File: tb/test_i2c_bank_mem_slave.sv
module test_i2c_bank_mem_slave;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] bank = 3'b101;
    logic       sda_oe;
    wire        sda_bus = sda_m & ~sda_oe;

    int n_cmp = 0;
    int n_err = 0;
    int bad_edges = 0;
    logic oe_prev = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_bank_mem_slave i_i2c_bank_mem_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .bank_sel (bank),
        .sda_oe   (sda_oe)
    );

    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m) bad_edges++;
        oe_prev <= sda_oe;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(); scl_m = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; hold(); scl_m = 1'b1; hold(); hold(); scl_m = 1'b0; hold();
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        b = sda_bus; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic rd_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic t_reset();
        check("R1 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_no_start();
        logic a;
        wr_byte(8'hAA, a);
        check("R12 byte without START not acked", {7'd0, a}, 8'h00);
    endtask

    task automatic t_write_burst();
        logic a;
        bus_start();
        wr_byte(8'hAA, a); check("R2 device byte acked", {7'd0, a}, 8'h01);
        wr_byte(8'h10, a); check("R4 word address acked", {7'd0, a}, 8'h01);
        wr_byte(8'h3C, a); check("R5 data 0 acked", {7'd0, a}, 8'h01);
        wr_byte(8'hC5, a); check("R5 data 1 acked", {7'd0, a}, 8'h01);
        wr_byte(8'h5A, a); check("R5 data 2 acked", {7'd0, a}, 8'h01);
        bus_stop();
    endtask

    task automatic t_random_read(input logic [7:0] adr, input logic [7:0] e0, input logic [7:0] e1, input string tag);
        logic a;
        logic [7:0] v;
        bus_start();
        wr_byte(8'hAA, a);
        wr_byte(adr, a);
        bus_start();
        wr_byte(8'hAB, a); check({tag, " read device byte acked (R2)"}, {7'd0, a}, 8'h01);
        rd_byte(v, 1'b1); check({tag, " first byte (R7 R9)"}, v, e0);
        rd_byte(v, 1'b0); check({tag, " next byte (R7)"}, v, e1);
        bit_in(a); check("R8 SDA released after NACK", {7'd0, a}, 8'h01);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic a;
        bus_start();
        wr_byte(8'hAA, a);
        wr_byte(8'hFF, a);
        wr_byte(8'h11, a);
        wr_byte(8'h22, a); check("R6 write past 255 acked", {7'd0, a}, 8'h01);
        bus_stop();
        t_random_read(8'hFF, 8'h11, 8'h22, "R6 wrap");
    endtask

    task automatic t_mismatch();
        logic a;
        logic [7:0] v;
        bus_start();
        wr_byte(8'h2A, a); check("R3 wrong type not acked", {7'd0, a}, 8'h00);
        wr_byte(8'h00, a); check("R3 later byte not acked", {7'd0, a}, 8'h00);
        wr_byte(8'h99, a); check("R3 data not acked", {7'd0, a}, 8'h00);
        bus_stop();
        bus_start();
        wr_byte(8'hA8, a); check("R3 wrong bank not acked", {7'd0, a}, 8'h00);
        wr_byte(8'h00, a);
        wr_byte(8'h98, a);
        bus_stop();
        bus_start();
        wr_byte(8'hAA, a);
        wr_byte(8'h00, a);
        bus_start();
        wr_byte(8'hAB, a);
        rd_byte(v, 1'b0); check("R3 memory untouched", v, 8'h22);
        bus_stop();
    endtask

    task automatic t_stop_and_restart();
        logic a;
        logic [7:0] v;
        wr_byte(8'hAA, a); check("R10 idle after STOP", {7'd0, a}, 8'h00);
        bus_start();
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        bus_start();
        wr_byte(8'hAA, a); check("R10 START mid-byte restarts", {7'd0, a}, 8'h01);
        wr_byte(8'h40, a);
        wr_byte(8'h66, a);
        bus_stop();
        bus_start();
        wr_byte(8'hAA, a);
        wr_byte(8'h40, a);
        bus_start();
        wr_byte(8'hAB, a);
        rd_byte(v, 1'b0); check("R10 data after restart", v, 8'h66);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_no_start();
        t_write_burst();
        t_random_read(8'h11, 8'hC5, 8'h5A, "R9 random");
        t_wrap();
        t_mismatch();
        t_stop_and_restart();
        check("R11 sda_oe edges during SCL high", bad_edges[7:0], 8'h00);
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end
endmodule